// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block holds the digital dividers that surround a frequency synthesizer loop. The reference clock is divided by p = P+2 and the oscillator clock is divided by m = M+8. Each of these two dividers gives a one-cycle pulse per division period, which feeds the phase detector. A post scaler divides the oscillator clock by 2^S to form the output clock. When the loop is locked, the output frequency is (M+8)·Fin / ((P+2)·2^S). The phase detector, charge pump, loop filter and oscillator sit outside this block.

Both clocks enter as level signals. A faster sampling clock `clk` oversamples them, and each divider counts the sampled rising edges. A 16-bit configuration word sets the three codes. The word packs M in bits [15:8], P in bits [7:2] and S in bits [1:0]. The word comes from a stored register written over a valid/ready port. For test, a select pin can route a second word straight past the register. A word with a P or M code outside the legal range raises an error flag and is not applied. A legal word is staged and adopted by each divider only when its current division period ends. A power-down input holds every output low.

The configuration port never applies back-pressure: `cfg_ready_o` stays high, and a word is captured on every clock edge that sees `cfg_valid_i` high.

Top module: `pll_div_chain`

## Requirements
- R1: With pre-divider code P, `ref_pulse_o` is high for exactly one `clk` cycle once every P+2 rising edges of `ref_i`.
- R2: With feedback code M, `fb_pulse_o` is high for exactly one `clk` cycle once every M+8 rising edges of `vco_i`, in the cycle right after an edge is sampled.
- R3: With S greater than 0, `clk_out_o` is high for 2^(S-1) periods of `vco_i` and low for 2^(S-1) periods, giving 50% duty.
- R4: With S = 0, `clk_out_o` follows `vco_i` one `clk` cycle later, with the same high and low times.
- R5: A word is legal only when 1 ≤ P ≤ 62 and 1 ≤ M ≤ 248. Two `clk` edges after an illegal word is requested, `cfg_err_o` is high, and the dividers keep running on the last legal setting. The values P=1, P=62, M=1 and M=248 are legal and leave `cfg_err_o` low.
- R6: `cfg_err_o` stays high while the requested word is illegal. It goes low once a legal word is requested.
- R7: While `pd_i` is high, both pulses and `clk_out_o` are low from the next cycle on. After release, the dividers restart from zero using the latest legal setting.
- R8: While `test_sel_i` is high, `test_word_i` replaces the stored word for legality checking and for the dividers. When `test_sel_i` goes low, the stored word governs again.
- R9: A new legal code does not shorten or stretch the division period in progress. That period completes with the old ratio, and the next period uses the new one.
- R10: During reset all outputs except `cfg_ready_o` are low. After reset the setting is P=1, M=1, S=0.
- R11: `cfg_ready_o` is always high, and a word presented with `cfg_valid_i` high is stored on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than both divided clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock level |
| vco_i | input | 1 | Oscillator clock level |
| pd_i | input | 1 | Power-down, holds all outputs low |
| cfg_valid_i | input | 1 | Configuration word valid |
| cfg_ready_o | output | 1 | Configuration ready, constant high |
| cfg_word_i | input | 16 | Configuration word {M, P, S} |
| test_sel_i | input | 1 | Selects the test word instead of the stored word |
| test_word_i | input | 16 | Test bypass word {M, P, S} |
| ref_pulse_o | output | 1 | Reference divider pulse |
| fb_pulse_o | output | 1 | Feedback divider pulse |
| clk_out_o | output | 1 | Post-scaled output clock |
| cfg_err_o | output | 1 | Requested word is illegal |

## Verification
The hardest case to reach is a code change that lands partway through a long division period. A faulty design could cut that period short or give it the new length without any steady-state measurement showing it. To expose this, the stimulus waits for a feedback pulse, writes the new M code on that same cycle, and times the interval that straddles the write before timing the one after it. A similar hidden fault is an illegal word silently replacing the running setting. So each illegal write is followed by a period measurement, which must still match the last legal ratio.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int M_W   = 8;
  localparam int P_W   = 6;
  localparam int S_W   = 2;
  localparam int CFG_W = M_W + P_W + S_W;
  localparam int P_OFS = 2;
  localparam int M_OFS = 8;

  localparam logic [P_W-1:0] P_LO = P_W'(1);
  localparam logic [P_W-1:0] P_HI = P_W'(62);
  localparam logic [M_W-1:0] M_LO = M_W'(1);
  localparam logic [M_W-1:0] M_HI = M_W'(248);

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
  } pll_cfg_t;

  function automatic logic cfg_ok(pll_cfg_t c);
    return (c.p >= P_LO) && (c.p <= P_HI) && (c.m >= M_LO) && (c.m <= M_HI);
  endfunction
endpackage

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_div_pkg::*;
#(
  parameter pll_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  pll_cfg_t wr_cfg,
  input  logic     byp_sel,
  input  pll_cfg_t byp_cfg,
  output pll_cfg_t act_cfg,
  output logic     err
);
  pll_cfg_t stored_q;
  pll_cfg_t req;

  // Word under consideration: bypass path or stored register
  always_comb req = byp_sel ? byp_cfg : stored_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= RST_CFG;
      act_cfg  <= RST_CFG;
      err      <= 1'b0;
    end else begin
      if (wr_en) stored_q <= wr_cfg;
      err <= !cfg_ok(req);
      if (cfg_ok(req)) act_cfg <= req;
    end
  end
endmodule

// File: rtl/pll_cnt_div.sv
module pll_cnt_div #(
  parameter int CODE_W   = 6,
  parameter int OFS      = 2,
  parameter int RST_CODE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  localparam int CNT_W = CODE_W + 1;

  logic [CODE_W-1:0] cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  last;

  // Terminal count is ratio-1 = code + OFS - 1
  always_comb last = {1'b0, cur_q} + CNT_W'(OFS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= CODE_W'(RST_CODE);
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else if (pd) begin
      cur_q   <= code_i;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (tick) begin
        if (cnt_q == last) begin
          cnt_q   <= '0;
          pulse_o <= 1'b1;
          cur_q   <= code_i;   // adopt new code at period end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_post_scale.sv
module pll_post_scale #(
  parameter int S_W   = 2,
  parameter int RST_S = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pd,
  input  logic           tick,
  input  logic           lvl,
  input  logic [S_W-1:0] s_i,
  output logic           out_o
);
  localparam int MAX_LOG = (1 << S_W) - 2;
  localparam int HC_W    = (MAX_LOG > 0) ? MAX_LOG : 1;

  logic [S_W-1:0]  cur_q;
  logic [HC_W-1:0] cnt_q;
  logic [HC_W-1:0] half_last;
  logic            bound;

  always_comb begin
    half_last = '0;
    if (cur_q != '0) half_last = HC_W'((32'd1 << (int'(cur_q) - 1)) - 32'd1);
  end

  // Period boundary: the edge at which the output starts a new high phase
  always_comb bound = tick && ((cur_q == '0) || ((cnt_q == half_last) && !out_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= S_W'(RST_S);
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (pd) begin
      cur_q <= s_i;
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (bound) begin
      cur_q <= s_i;
      cnt_q <= '0;
      out_o <= 1'b1;
    end else if (cur_q == '0) begin
      out_o <= lvl;
    end else if (tick) begin
      if (cnt_q == half_last) begin
        cnt_q <= '0;
        out_o <= ~out_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain
  import pll_div_pkg::*;
#(
  parameter int RST_M = 1,
  parameter int RST_P = 1,
  parameter int RST_S = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             vco_i,
  input  logic             pd_i,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [CFG_W-1:0] cfg_word_i,
  input  logic             test_sel_i,
  input  logic [CFG_W-1:0] test_word_i,
  output logic             ref_pulse_o,
  output logic             fb_pulse_o,
  output logic             clk_out_o,
  output logic             cfg_err_o
);
  localparam pll_cfg_t RST_CFG = '{m: M_W'(RST_M), p: P_W'(RST_P), s: S_W'(RST_S)};

  pll_cfg_t act;
  logic     ref_q, vco_q;
  logic     ref_rise, vco_rise;

  assign cfg_ready_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else begin
      ref_q <= ref_i;
      vco_q <= vco_i;
    end
  end

  always_comb begin
    ref_rise = ref_i & ~ref_q;
    vco_rise = vco_i & ~vco_q;
  end

  pll_cfg_ctrl #(.RST_CFG(RST_CFG)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_valid_i),
    .wr_cfg  (pll_cfg_t'(cfg_word_i)),
    .byp_sel (test_sel_i),
    .byp_cfg (pll_cfg_t'(test_word_i)),
    .act_cfg (act),
    .err     (cfg_err_o)
  );

  pll_cnt_div #(.CODE_W(P_W), .OFS(P_OFS), .RST_CODE(RST_P)) u_pre (
    .clk(clk), .rst_n(rst_n), .pd(pd_i), .tick(ref_rise),
    .code_i(act.p), .pulse_o(ref_pulse_o)
  );

  pll_cnt_div #(.CODE_W(M_W), .OFS(M_OFS), .RST_CODE(RST_M)) u_fb (
    .clk(clk), .rst_n(rst_n), .pd(pd_i), .tick(vco_rise),
    .code_i(act.m), .pulse_o(fb_pulse_o)
  );

  pll_post_scale #(.S_W(S_W), .RST_S(RST_S)) u_post (
    .clk(clk), .rst_n(rst_n), .pd(pd_i), .tick(vco_rise),
    .lvl(vco_i), .s_i(act.s), .out_o(clk_out_o)
  );
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk
  import pll_div_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             vco_i,
  input logic             pd_i,
  input logic             cfg_valid_i,
  input logic [CFG_W-1:0] cfg_word_i,
  input logic             test_sel_i,
  input logic [CFG_W-1:0] test_word_i,
  input logic             ref_pulse_o,
  input logic             fb_pulse_o,
  input logic             clk_out_o,
  input logic             cfg_err_o
);
  // R1
  ref_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse_o |=> !ref_pulse_o);

  // R2
  fb_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse_o |=> !fb_pulse_o);

  // R2
  fb_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse_o |-> ($past(vco_i) && !$past(vco_i, 2)));

  // R7
  pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> (!ref_pulse_o && !fb_pulse_o && !clk_out_o));

  // R5
  bad_word_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid_i && !cfg_ok(pll_cfg_t'(cfg_word_i))) ##1 !test_sel_i |=> cfg_err_o);

  // R8
  byp_bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel_i && !cfg_ok(pll_cfg_t'(test_word_i))) |=> cfg_err_o);

  // R6
  byp_good_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel_i && cfg_ok(pll_cfg_t'(test_word_i))) |=> !cfg_err_o);
endmodule

bind pll_div_chain pll_div_chain_chk chk_i (
  .clk(clk), .rst_n(rst_n), .vco_i(vco_i), .pd_i(pd_i),
  .cfg_valid_i(cfg_valid_i), .cfg_word_i(cfg_word_i),
  .test_sel_i(test_sel_i), .test_word_i(test_word_i),
  .ref_pulse_o(ref_pulse_o), .fb_pulse_o(fb_pulse_o),
  .clk_out_o(clk_out_o), .cfg_err_o(cfg_err_o)
);

// File: tb/pll_div_chain_tb_top.sv
`timescale 1ns/1ps
module pll_div_chain_tb_top;
  localparam int RH = 3;        // ref half period in clk cycles
  localparam int VH = 2;        // vco half period in clk cycles
  localparam int RP = 2 * RH;
  localparam int VP = 2 * VH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_i = 1'b0, vco_i = 1'b0, pd_i = 1'b0;
  logic cfg_valid_i = 1'b0, test_sel_i = 1'b0;
  logic [15:0] cfg_word_i = '0, test_word_i = '0;
  logic cfg_ready_o, ref_pulse_o, fb_pulse_o, clk_out_o, cfg_err_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  initial forever begin repeat (RH) @(negedge clk); ref_i = ~ref_i; end
  initial forever begin repeat (VH) @(negedge clk); vco_i = ~vco_i; end

  pll_div_chain dut_i (
    .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .vco_i(vco_i), .pd_i(pd_i),
    .cfg_valid_i(cfg_valid_i), .cfg_ready_o(cfg_ready_o), .cfg_word_i(cfg_word_i),
    .test_sel_i(test_sel_i), .test_word_i(test_word_i),
    .ref_pulse_o(ref_pulse_o), .fb_pulse_o(fb_pulse_o),
    .clk_out_o(clk_out_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [15:0] word(int m, int p, int s);
    return {8'(m), 6'(p), 2'(s)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(int m, int p, int s);
    @(negedge clk);
    chk(cfg_ready_o === 1'b1, "R11 ready", int'(cfg_ready_o), 1);
    cfg_valid_i = 1'b1;
    cfg_word_i  = word(m, p, s);
    @(negedge clk);
    cfg_valid_i = 1'b0;
  endtask

  function automatic logic sel_sig(int sel);
    return (sel == 0) ? ref_pulse_o : fb_pulse_o;
  endfunction

  // Interval in clk cycles between two pulses; also checks one-cycle width
  task automatic gap_of(int sel, string req, output int g);
    int t = 0;
    g = -1;
    while (sel_sig(sel) !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(sel_sig(sel) === 1'b0, req, int'(sel_sig(sel)), 0);
    g = 1;
    while (sel_sig(sel) !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
  endtask

  task automatic steady_gap(int sel, string req, int exp);
    int g;
    gap_of(sel, req, g);
    gap_of(sel, req, g);
    gap_of(sel, req, g);
    chk(g == exp, req, g, exp);
  endtask

  task automatic hi_lo(output int hi, output int lo);
    int t = 0;
    while (clk_out_o !== 1'b0 && t < 500) begin @(negedge clk); t++; end
    while (clk_out_o !== 1'b1 && t < 1000) begin @(negedge clk); t++; end
    hi = 0; lo = 0;
    while (clk_out_o === 1'b1 && hi < 500) begin @(negedge clk); hi++; end
    while (clk_out_o === 1'b0 && lo < 500) begin @(negedge clk); lo++; end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(ref_pulse_o === 1'b0 && fb_pulse_o === 1'b0 && clk_out_o === 1'b0,
        "R10 outputs low in reset", int'({ref_pulse_o, fb_pulse_o, clk_out_o}), 0);
    chk(cfg_err_o === 1'b0, "R10 err low", int'(cfg_err_o), 0);
    chk(cfg_ready_o === 1'b1, "R11 ready in reset", int'(cfg_ready_o), 1);
    rst_n = 1'b1;
    steady_gap(0, "R10 default pre ratio", 3 * RP);
    steady_gap(1, "R10 default fb ratio", 9 * VP);
  endtask

  task automatic test_pre_div();
    write_cfg(1, 5, 0);
    steady_gap(0, "R1 P=5", 7 * RP);
    write_cfg(1, 62, 0);
    steady_gap(0, "R1 P=62", 64 * RP);
    chk(cfg_err_o === 1'b0, "R5 P=62 legal", int'(cfg_err_o), 0);
  endtask

  task automatic test_fb_div();
    write_cfg(248, 1, 0);
    steady_gap(1, "R2 M=248", 256 * VP);
    chk(cfg_err_o === 1'b0, "R5 M=248 P=1 legal", int'(cfg_err_o), 0);
    write_cfg(20, 5, 0);
    steady_gap(1, "R2 M=20", 28 * VP);
  endtask

  task automatic test_post();
    int hi, lo;
    for (int s = 1; s <= 3; s++) begin
      write_cfg(20, 5, s);
      hi_lo(hi, lo); hi_lo(hi, lo);
      chk(hi == (1 << (s - 1)) * VP, "R3 high time", hi, (1 << (s - 1)) * VP);
      chk(lo == (1 << (s - 1)) * VP, "R3 low time", lo, (1 << (s - 1)) * VP);
    end
    write_cfg(20, 5, 0);
    hi_lo(hi, lo); hi_lo(hi, lo);
    chk(hi == VH && lo == VH, "R4 passthrough", hi * 100 + lo, VH * 100 + VH);
  endtask

  task automatic test_illegal();
    int bad_m[4] = '{20, 20, 0, 249};
    int bad_p[4] = '{0, 63, 5, 5};
    for (int i = 0; i < 4; i++) begin
      write_cfg(bad_m[i], bad_p[i], 1);
      @(negedge clk);
      chk(cfg_err_o === 1'b1, "R5 illegal flagged", int'(cfg_err_o), 1);
    end
    steady_gap(0, "R5 old pre ratio kept", 7 * RP);
    steady_gap(1, "R5 old fb ratio kept", 28 * VP);
    chk(cfg_err_o === 1'b1, "R6 flag persists", int'(cfg_err_o), 1);
    write_cfg(20, 5, 0);
    @(negedge clk);
    chk(cfg_err_o === 1'b0, "R6 flag cleared", int'(cfg_err_o), 0);
  endtask

  task automatic test_boundary();
    int g, t;
    steady_gap(1, "R9 setup", 28 * VP);
    t = 0;
    while (fb_pulse_o !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    cfg_valid_i = 1'b1;
    cfg_word_i  = word(40, 5, 0);
    g = 0;
    do begin
      @(negedge clk);
      g++;
      if (g == 1) cfg_valid_i = 1'b0;
    end while (fb_pulse_o !== 1'b1 && g < 3000);
    chk(g == 28 * VP, "R9 period in progress keeps old ratio", g, 28 * VP);
    gap_of(1, "R9 width", g);
    chk(g == 48 * VP, "R9 next period new ratio", g, 48 * VP);
  endtask

  task automatic test_pd();
    bit quiet = 1;
    @(negedge clk);
    pd_i = 1'b1;
    @(negedge clk);
    write_cfg(30, 10, 0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ref_pulse_o !== 1'b0 || fb_pulse_o !== 1'b0 || clk_out_o !== 1'b0) quiet = 0;
    end
    chk(quiet, "R7 outputs held low", int'(quiet), 1);
    pd_i = 1'b0;
    steady_gap(1, "R7 fb after release", 38 * VP);
    steady_gap(0, "R7 pre after release", 12 * RP);
  endtask

  task automatic test_mux();
    write_cfg(20, 5, 0);
    @(negedge clk);
    test_word_i = word(10, 5, 0);
    test_sel_i  = 1'b1;
    steady_gap(1, "R8 bypass word used", 18 * VP);
    @(negedge clk);
    test_word_i = word(0, 5, 0);
    @(negedge clk);
    chk(cfg_err_o === 1'b1, "R8 bypass illegal flagged", int'(cfg_err_o), 1);
    steady_gap(1, "R8 bypass illegal keeps ratio", 18 * VP);
    @(negedge clk);
    test_sel_i = 1'b0;
    @(negedge clk);
    chk(cfg_err_o === 1'b0, "R8 stored word again", int'(cfg_err_o), 0);
    steady_gap(1, "R8 stored ratio back", 28 * VP);
  endtask

  initial begin
    test_reset();
    test_pre_div();
    test_fb_div();
    test_post();
    test_illegal();
    test_boundary();
    test_pd();
    test_mux();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule